// File: doc/BRIEF.md
# Double-Data-Rate Serial Output Stage

This block drives one output line at twice the bit rate of its clock. A parallel word arrives over a valid/ready handshake. A small serializer then presents the word as bit pairs, most significant pair first, with one pair per clock cycle. Each bit of a pair is held by its own single-edge register: the "lead" register and the "trail" register. A 2:1 multiplexer whose select input is the clock itself alternates between the two registers. As a result, every bit occupies exactly one half of a clock period on the line.

Three compile-time parameters fix the capture edge of each register and the polarity of the select signal. A "true" select follows the clock, and it routes the trail register while the clock is high. An "inverted" select follows the complement of the clock. Of the eight combinations, only four put the lead bit on the line before the trail bit. These are:

- rise/rise/inverted
- fall/rise/true
- fall/rise/inverted
- fall/fall/true

Elaboration stops on any of the other four. The default is fall/rise/inverted, in which both registers are shown during the later half of their hold window. A data path that arrives late therefore still has half a cycle of slack before the bit order breaks.

Top module: `ddr_out_stage`

## Requirements
- R1: Within every accepted pair, the lead bit (the higher-indexed bit of the pair) is driven on the line for one full half-period, immediately followed by the trail bit for one full half-period.
- R2: With the inverted select, the lead bit of pair j of a word accepted at rising edge E occupies the high phase of cycle E+1+j, and its trail bit occupies the low phase that follows it.
- R3: With the true select, the lead bit of pair j of a word accepted at rising edge E occupies the low phase of cycle E+j, and its trail bit occupies the high phase of cycle E+1+j.
- R4: The package predicate accepts exactly four configurations, written as (lead edge, trail edge, select): (rise, rise, inv), (fall, rise, true), (fall, rise, inv) and (fall, fall, true). Its argument encoding is rise=1, fall=0, inv=1, true=0. Elaborating the top with any other combination fails.
- R5: With no parameter overrides, the top uses lead=fall, trail=rise, select=inverted, and it therefore follows the R2 timing.
- R6: The word is serialized from bit N-1 downward, two bits per cycle. A word accepted as soon as ready allows continues the line with no idle half-period after the previous word.
- R7: `word_ready_o` is low for the N/2-1 cycles that follow an accepting edge. It is high again in the cycle that presents the word's last pair.
- R8: `word_valid_i` has no effect while `word_ready_o` is low. The line is 0 in every half-period that carries no accepted bit.
- R9: A synchronous active-high reset leaves `word_ready_o` high and the line at 0 until a word is accepted after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the multiplexer select |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | WORD_W | Parallel word to serialize |
| word_valid_i | input | 1 | Word on `word_i` is offered |
| word_ready_o | output | 1 | Stage can take a word at the next rising edge |
| ddr_o | output | 1 | Serial line, one bit per half clock period |

## Verification
A word is taken at the rising edge where valid and ready are both high, and its first pair is registered at that same edge. The first line bit then follows one full cycle later for an inverted select, or half a cycle later for a true select. Each later pair follows one cycle after the one before it. Ready falls right after the accepting edge and rises N/2-1 cycles later.

The bench records the line 3 ns into every 5 ns half-period, tagged with a half-period index taken from its own edge counter. It rebuilds each word from the indices that R2 or R3 predict for the accepting edge it logged. It checks every unclaimed half-period for 0. Inputs change 1 ns after the falling edge, so they never coincide with a capture edge.

// File: rtl/ddr_pkg.sv
`timescale 1ns/1ps
package ddr_pkg;

    // Capture edge of a single-edge register
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } cap_edge_e;

    // Multiplexer select: true clock or its complement
    typedef enum logic {
        SEL_TRUE = 1'b0,
        SEL_INV  = 1'b1
    } sel_pol_e;

    // One cycle's worth of line data
    typedef struct packed {
        logic lead;
        logic trail;
    } bit_pair_t;

    // Ordering holds only when the lead bit leaves before the trail bit.
    function automatic logic cfg_legal(cap_edge_e lead_edge,
                                       cap_edge_e trail_edge,
                                       sel_pol_e  sel_pol);
        logic [2:0] key;
        key = {lead_edge, trail_edge, sel_pol};
        case (key)
            3'b111,            // rise, rise, inverted
            3'b010,            // fall, rise, true
            3'b011,            // fall, rise, inverted
            3'b000: return 1'b1; // fall, fall, true
            default: return 1'b0;
        endcase
    endfunction

    // Top pair of a word, most significant bit leads
    function automatic bit_pair_t top_pair(logic msb, logic next);
        bit_pair_t p;
        p.lead  = msb;
        p.trail = next;
        return p;
    endfunction

endpackage

// File: rtl/ddr_pair_serializer.sv
`timescale 1ns/1ps
module ddr_pair_serializer
    import ddr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              ready_o,
    output bit_pair_t         pair_o
);

    localparam int PAIRS = WORD_W / 2;
    localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    logic [WORD_W-1:0] shift_q;
    logic [CNT_W-1:0]  left_q;
    bit_pair_t         pair_q;
    logic              take;

    // Ready while the current pair is the last one (or nothing is pending)
    assign ready_o = (left_q == '0);
    assign take    = valid_i && ready_o;
    assign pair_o  = pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            left_q  <= '0;
            pair_q  <= '0;
        end else if (take) begin
            pair_q  <= top_pair(word_i[WORD_W-1], word_i[WORD_W-2]);
            shift_q <= word_i << 2;
            left_q  <= CNT_W'(PAIRS - 1);
        end else if (left_q != '0) begin
            pair_q  <= top_pair(shift_q[WORD_W-1], shift_q[WORD_W-2]);
            shift_q <= shift_q << 2;
            left_q  <= left_q - CNT_W'(1);
        end else begin
            pair_q  <= '0;
        end
    end

endmodule

// File: rtl/ddr_edge_reg.sv
`timescale 1ns/1ps
module ddr_edge_reg
    import ddr_pkg::*;
#(
    parameter cap_edge_e EDGE = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    if (EDGE == EDGE_RISE) begin : g_rise
        always_ff @(posedge clk) begin
            if (rst) q_o <= 1'b0;
            else     q_o <= d_i;
        end
    end else begin : g_fall
        always_ff @(negedge clk) begin
            if (rst) q_o <= 1'b0;
            else     q_o <= d_i;
        end
    end

endmodule

// File: rtl/ddr_clk_mux.sv
`timescale 1ns/1ps
module ddr_clk_mux
    import ddr_pkg::*;
#(
    parameter sel_pol_e POL = SEL_INV
) (
    input  logic clk,
    input  logic lead_i,
    input  logic trail_i,
    output logic y_o
);

    logic sel;

    if (POL == SEL_INV) begin : g_inv
        assign sel = ~clk;
    end else begin : g_true
        assign sel = clk;
    end

    // input 0 = lead register, input 1 = trail register
    always_comb y_o = sel ? trail_i : lead_i;

endmodule

// File: rtl/ddr_out_stage.sv
`timescale 1ns/1ps
module ddr_out_stage
    import ddr_pkg::*;
#(
    parameter int        WORD_W     = 16,
    parameter cap_edge_e LEAD_EDGE  = EDGE_FALL,
    parameter cap_edge_e TRAIL_EDGE = EDGE_RISE,
    parameter sel_pol_e  SEL_POL    = SEL_INV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    output logic              ddr_o
);

    // Elaboration guards
    if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
        $error("ddr_out_stage: WORD_W must be even and at least 2");
    end
    if (!cfg_legal(LEAD_EDGE, TRAIL_EDGE, SEL_POL)) begin : g_bad_cfg
        $error("ddr_out_stage: edge/select combination emits trail before lead");
    end

    bit_pair_t pair_q;
    logic      pair_lead;
    logic      pair_trail;
    logic      lead_q;
    logic      trail_q;

    ddr_pair_serializer #(
        .WORD_W (WORD_W)
    ) u_ser (
        .clk     (clk),
        .rst     (rst),
        .word_i  (word_i),
        .valid_i (word_valid_i),
        .ready_o (word_ready_o),
        .pair_o  (pair_q)
    );

    assign pair_lead  = pair_q.lead;
    assign pair_trail = pair_q.trail;

    ddr_edge_reg #(
        .EDGE (LEAD_EDGE)
    ) u_lead (
        .clk (clk),
        .rst (rst),
        .d_i (pair_lead),
        .q_o (lead_q)
    );

    ddr_edge_reg #(
        .EDGE (TRAIL_EDGE)
    ) u_trail (
        .clk (clk),
        .rst (rst),
        .d_i (pair_trail),
        .q_o (trail_q)
    );

    ddr_clk_mux #(
        .POL (SEL_POL)
    ) u_mux (
        .clk     (clk),
        .lead_i  (lead_q),
        .trail_i (trail_q),
        .y_o     (ddr_o)
    );

endmodule

// File: rtl/ddr_out_checker.sv
`timescale 1ns/1ps
module ddr_out_checker
    import ddr_pkg::*;
#(
    parameter int       WORD_W  = 16,
    parameter sel_pol_e SEL_POL = SEL_INV
) (
    input logic clk,
    input logic rst,
    input logic word_valid_i,
    input logic word_ready_o,
    input logic ddr_o,
    input logic pair_lead,
    input logic pair_trail
);

    localparam int PAIRS = WORD_W / 2;
    localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    // Independent count of cycles a word still occupies the serializer
    logic [CNT_W-1:0] busy_q;
    always_ff @(posedge clk) begin
        if (rst)                               busy_q <= '0;
        else if (word_valid_i && word_ready_o) busy_q <= CNT_W'(PAIRS - 1);
        else if (busy_q != '0)                 busy_q <= busy_q - CNT_W'(1);
    end

    // R7
    ready_window_chk: assert property (@(posedge clk) disable iff (rst)
        word_ready_o == (busy_q == '0));

    // R7
    ready_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(word_ready_o) |-> $past(word_valid_i && word_ready_o));

    if (SEL_POL == SEL_INV) begin : g_late
        // R2
        lead_half_late_chk: assert property (@(negedge clk) disable iff (rst)
            ddr_o == $past(pair_lead));
        // R2
        trail_half_late_chk: assert property (@(posedge clk) disable iff (rst)
            ddr_o == $past(pair_trail));
    end else begin : g_early
        // R3
        lead_half_early_chk: assert property (@(posedge clk) disable iff (rst)
            ddr_o == pair_lead);
        // R3
        trail_half_early_chk: assert property (@(negedge clk) disable iff (rst)
            ddr_o == $past(pair_trail));
    end

endmodule

bind ddr_out_stage ddr_out_checker #(
    .WORD_W  (WORD_W),
    .SEL_POL (SEL_POL)
) u_ddr_chk (
    .clk          (clk),
    .rst          (rst),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .ddr_o        (ddr_o),
    .pair_lead    (pair_lead),
    .pair_trail   (pair_trail)
);

// File: tb/tb_ddr_out_stage.sv
`timescale 1ns/1ps
module tb_ddr_out_stage;
    import ddr_pkg::*;

    localparam int W     = 16;
    localparam int NP    = W / 2;
    localparam int MAXH  = 1024;
    localparam int NVEC  = 8;
    localparam int NDUT  = 4;
    localparam int WD_NS = 200000 * 10;

    // stimulus table: word and idle cycles before offering it
    localparam logic [W-1:0] VEC_WORD [NVEC] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001,
                                                 16'h1234, 16'hF00F, 16'h5555, 16'hC0DE};
    localparam int           VEC_GAP  [NVEC] = '{0, 0, 3, 0, 1, 0, 5, 0};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [W-1:0]  word_i = '0;
    logic          word_valid_i = 1'b0;
    logic [NDUT-1:0] ddr_w;
    logic [NDUT-1:0] rdy_w;

    // 0: rise/rise/inv  1: fall/fall/true  2: fall/rise/true  3: defaults
    ddr_out_stage #(.WORD_W(W), .LEAD_EDGE(EDGE_RISE), .TRAIL_EDGE(EDGE_RISE), .SEL_POL(SEL_INV))
        dut_rri (.clk(clk), .rst(rst), .word_i(word_i), .word_valid_i(word_valid_i),
                 .word_ready_o(rdy_w[0]), .ddr_o(ddr_w[0]));
    ddr_out_stage #(.WORD_W(W), .LEAD_EDGE(EDGE_FALL), .TRAIL_EDGE(EDGE_FALL), .SEL_POL(SEL_TRUE))
        dut_fft (.clk(clk), .rst(rst), .word_i(word_i), .word_valid_i(word_valid_i),
                 .word_ready_o(rdy_w[1]), .ddr_o(ddr_w[1]));
    ddr_out_stage #(.WORD_W(W), .LEAD_EDGE(EDGE_FALL), .TRAIL_EDGE(EDGE_RISE), .SEL_POL(SEL_TRUE))
        dut_frt (.clk(clk), .rst(rst), .word_i(word_i), .word_valid_i(word_valid_i),
                 .word_ready_o(rdy_w[2]), .ddr_o(ddr_w[2]));
    ddr_out_stage #(.WORD_W(W))
        dut (.clk(clk), .rst(rst), .word_i(word_i), .word_valid_i(word_valid_i),
             .word_ready_o(rdy_w[3]), .ddr_o(ddr_w[3]));

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic rec_q [NDUT][MAXH];
    bit   cov_q [NDUT][MAXH];
    int   acc_edge [32];
    logic [W-1:0] acc_word [32];
    int   n_acc = 0;

    // mid-phase recorder: index 2c = high phase of cycle c, 2c+1 = low phase
    always begin
        @(posedge clk); #3;
        for (int d = 0; d < NDUT; d++) if (2*cyc+1 < MAXH) rec_q[d][2*cyc] = ddr_w[d];
        @(negedge clk); #3;
        for (int d = 0; d < NDUT; d++) if (2*cyc+1 < MAXH) rec_q[d][2*cyc+1] = ddr_w[d];
    end

    function automatic bit is_late(int d);
        return (d == 0) || (d == 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // offer a word, wait for acceptance, log the accepting edge
    task automatic send_word(input logic [W-1:0] w);
        word_i       = w;
        word_valid_i = 1'b1;
        while (rdy_w[0] !== 1'b1) tick();
        acc_edge[n_acc] = cyc + 1;
        acc_word[n_acc] = w;
        n_acc++;
        tick();
        word_valid_i = 1'b0;
    endtask

    initial begin
        #(WD_NS);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int h_lo;
        int h_hi;
        for (int d = 0; d < NDUT; d++)
            for (int h = 0; h < MAXH; h++) begin
                rec_q[d][h] = 1'b0;
                cov_q[d][h] = 1'b0;
            end

        tick(); tick(); tick();
        rst = 1'b0;
        h_lo = 2 * (cyc + 1);
        // R9: reset state
        chk(rdy_w == 4'hF, "R9", "ready after reset", 32'(rdy_w), 32'hF);
        chk(ddr_w == 4'h0, "R9", "line after reset", 32'(ddr_w), 32'h0);
        tick();
        chk(ddr_w == 4'h0, "R9", "line idle after release", 32'(ddr_w), 32'h0);

        // R4: legality predicate over all eight combinations
        for (int c = 0; c < 8; c++) begin
            bit exp_ok;
            bit got;
            exp_ok = (c == 7) || (c == 2) || (c == 3) || (c == 0);
            got = cfg_legal(cap_edge_e'(c[2]), cap_edge_e'(c[1]), sel_pol_e'(c[0]));
            chk(got == exp_ok, "R4", "config legality", 32'(got), 32'(exp_ok));
        end

        // table walk (R6: back-to-back where gap is 0)
        for (int v = 0; v < NVEC; v++) begin
            for (int g = 0; g < VEC_GAP[v]; g++) tick();
            send_word(VEC_WORD[v]);
        end

        // R7: ready window after an accepting edge
        send_word(16'h6A3C);
        for (int k = 0; k < NP - 1; k++) begin
            chk(rdy_w == 4'h0, "R7", "ready low while busy", 32'(rdy_w), 32'h0);
            tick();
        end
        chk(rdy_w == 4'hF, "R7", "ready back on last pair", 32'(rdy_w), 32'hF);

        // R8: offer while busy is ignored
        send_word(16'h9009);
        word_i       = 16'hFFFF;
        word_valid_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(rdy_w == 4'h0, "R8", "ready stays low under offer", 32'(rdy_w), 32'h0);
        end
        word_valid_i = 1'b0;
        for (int k = 0; k < 14; k++) tick();
        h_hi = 2 * cyc - 2;

        // rebuild every word per instance (R1 order, R2/R3/R5 timing, R6 MSB first)
        for (int d = 0; d < NDUT; d++) begin
            int bad;
            for (int i = 0; i < n_acc; i++) begin
                logic [W-1:0] got_w;
                for (int j = 0; j < NP; j++) begin
                    int hl;
                    hl = is_late(d) ? 2 * (acc_edge[i] + 1 + j) : 2 * (acc_edge[i] + j) + 1;
                    got_w[W-1-2*j] = rec_q[d][hl];
                    got_w[W-2-2*j] = rec_q[d][hl+1];
                    cov_q[d][hl]   = 1'b1;
                    cov_q[d][hl+1] = 1'b1;
                end
                if (d == 3)
                    chk(got_w == acc_word[i], "R5", "default config word", 32'(got_w), 32'(acc_word[i]));
                else if (is_late(d))
                    chk(got_w == acc_word[i], "R1 R2 R6", "inv-select word", 32'(got_w), 32'(acc_word[i]));
                else
                    chk(got_w == acc_word[i], "R1 R3 R6", "true-select word", 32'(got_w), 32'(acc_word[i]));
            end
            // R8: nothing else on the line
            bad = 0;
            for (int h = h_lo; h <= h_hi; h++)
                if (!cov_q[d][h] && rec_q[d][h] !== 1'b0) bad++;
            chk(bad == 0, "R8", "idle half-periods high", 32'(bad), 32'h0);
        end

        // R9: reset in the middle of a word
        send_word(16'hFFFF);
        tick(); tick();
        rst = 1'b1;
        tick(); tick(); tick();
        rst = 1'b0;
        chk(rdy_w == 4'hF, "R9", "ready after mid-word reset", 32'(rdy_w), 32'hF);
        chk(ddr_w == 4'h0, "R9", "line after mid-word reset", 32'(ddr_w), 32'h0);
        @(posedge clk); #3;
        chk(ddr_w == 4'h0, "R9", "line high phase after reset", 32'(ddr_w), 32'h0);
        tick();
        finish_run();
    end

endmodule